// File: doc/BRIEF.md
# Writeback Port Conflict Scheduler

This block issues instructions into a short in-order pipeline and schedules their register writes. The pipeline has one register-file write port. A memory-reading instruction writes in its fifth stage. A register-to-register instruction skips the memory stage, so on its natural path it writes in its fourth stage. If a short instruction follows a long one directly, both would need the port in the same cycle. The block tracks every instruction in flight, so that the port is never granted twice in one cycle.

An upstream source offers one instruction per cycle with a valid/ready handshake. The offer carries a tag and a kind bit. A mode input picks how a collision is avoided:

- **Stall mode:** short instructions keep their four-stage path. The block withholds ready for one cycle whenever issuing would collide.
- **Pad mode:** every short instruction gets an idle memory stage, so all writes land in stage five and issue never stops.

Each in-flight instruction occupies a write slot. The slot index is its remaining cycle count. Three counters report accepted instructions, stall cycles and completed writes, so throughput can be compared between modes.

Top module: `wbs_writeback_sched`

## Requirements
- R1: While `rst_n` is low, `in_ready` and `wb_en` are 0. One clock edge with `rst_n` low clears all counters and in-flight entries.
- R2: A load (`in_is_load`=1) accepted in cycle c raises `wb_en` in cycle c+4 with its tag, and in none of cycles c+1 to c+3.
- R3: In stall mode (`mode_pad`=0), a short instruction (`in_is_load`=0) accepted in cycle c writes in cycle c+3 with its tag.
- R4: In stall mode, a short instruction offered in the cycle right after a load was accepted sees `in_ready`=0 for exactly one cycle. It is accepted in the following cycle.
- R5: In pad mode (`mode_pad`=1), `in_ready` is 1 whenever `rst_n` is high. A short instruction accepted in cycle c writes in cycle c+4.
- R6: At most one write is granted per cycle, and writes leave in the order the instructions were accepted.
- R7: A back-to-back stream with no collision completes one write per cycle, on consecutive cycles, once the pipeline has filled.
- R8: `cnt_issued` counts accepted instructions. `cnt_bubbles` counts cycles with `in_valid`=1 and `in_ready`=0. `cnt_writes` counts cycles with `wb_en`=1.
- R9: With `in_valid` low nothing is accepted, and no write appears later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_pad | input | 1 | 0 = stall on collision, 1 = pad short instructions to five stages |
| in_valid | input | 1 | Upstream offers an instruction |
| in_ready | output | 1 | Offer accepted at this clock edge |
| in_tag | input | TAG_W | Tag of the offered instruction |
| in_is_load | input | 1 | 1 = five-stage load, 0 = register-to-register instruction |
| wb_en | output | 1 | Register write granted this cycle |
| wb_tag | output | TAG_W | Tag of the instruction writing this cycle |
| cnt_issued | output | CNT_W | Accepted-instruction count |
| cnt_bubbles | output | CNT_W | Stall-cycle count |
| cnt_writes | output | CNT_W | Completed-write count |

## Verification
The hardest case to reach is a collision. It only arises when a short instruction is offered in stall mode in the very cycle after a load was accepted. An idle cycle between the two hides it completely.

The bench offers each instruction in the cycle right after the previous acceptance. It then runs mixed load/short streams, so that the one-cycle stall, the gap it leaves on the write port, and the in-order write sequence can all be compared against cycle numbers taken at the handshake.

// File: rtl/wbs_pkg.sv
// Shared definitions for the writeback scheduler.
// Assumes a single register-file write port and two instruction lengths.
package wbs_pkg;

    // How a collision on the write port is avoided.
    typedef enum logic {
        WB_STALL = 1'b0,
        WB_PAD   = 1'b1
    } wb_mode_e;

    // Slot index an instruction takes when it enters the schedule,
    // given its stage count: stage 1 is the issue cycle, and the
    // slot shift at the issue edge uses one more.
    function automatic int entry_slot(input int stages);
        return stages - 2;
    endfunction

endpackage

// File: rtl/wbs_issue_ctrl.sv
// Issue control: decides whether the offered instruction may start
// this cycle, and which write slot it will occupy.
// Assumes slot_busy reflects the schedule before this cycle's shift,
// so slot k+1 now becomes slot k after the edge.
module wbs_issue_ctrl
    import wbs_pkg::*;
#(
    parameter int LOAD_STAGES = 5,
    parameter int ALU_STAGES  = 4,
    localparam int NSLOT      = LOAD_STAGES - 1,
    localparam int POS_W      = $clog2(NSLOT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_pad,
    input  logic             in_valid,
    input  logic             in_is_load,
    input  logic [NSLOT-1:0] slot_busy,
    output logic             in_ready,
    output logic             ins_valid,
    output logic [POS_W-1:0] ins_pos,
    output logic             bubble
);

    localparam int LOAD_POS = entry_slot(LOAD_STAGES);
    localparam int ALU_POS  = entry_slot(ALU_STAGES);

    logic [NSLOT:0]   busy_ext;
    logic [POS_W-1:0] target;
    logic             clash;

    // Purpose: pick the write slot from the kind and the mode.
    always_comb begin
        if (in_is_load || (wb_mode_e'(mode_pad) == WB_PAD)) begin
            target = POS_W'(LOAD_POS);
        end else begin
            target = POS_W'(ALU_POS);
        end
    end

    // Purpose: detect a slot already taken once the schedule shifts.
    always_comb begin
        busy_ext = {1'b0, slot_busy};
        clash    = busy_ext[POS_W'(target + 1'b1)];
    end

    // Purpose: handshake and stall outputs.
    always_comb begin
        in_ready  = rst_n && !clash;
        ins_valid = in_valid && in_ready;
        ins_pos   = target;
        bubble    = rst_n && in_valid && clash;
    end

    // R5: padding mode never holds the source back
    p_pad_no_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_pad |-> in_ready);

    // R4: a stall cycle never also accepts the instruction
    p_bubble_no_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |-> !ins_valid);

endmodule

// File: rtl/wbs_slot_track.sv
// Slot tracker: one entry per remaining cycle before writeback.
// Slot 0 is the instruction writing this cycle. Every edge moves each
// entry one slot down, and the newly issued instruction is placed at
// ins_pos. Assumes issue control never targets an occupied slot.
module wbs_slot_track #(
    parameter int TAG_W       = 4,
    parameter int LOAD_STAGES = 5,
    localparam int NSLOT      = LOAD_STAGES - 1,
    localparam int POS_W      = $clog2(NSLOT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [POS_W-1:0] ins_pos,
    input  logic [TAG_W-1:0] ins_tag,
    output logic [NSLOT-1:0] slot_busy,
    output logic             wb_en,
    output logic [TAG_W-1:0] wb_tag
);

    logic [NSLOT-1:0] v_q;
    logic [TAG_W-1:0] tag_q [NSLOT];
    logic [NSLOT:0]   v_ext;
    logic [TAG_W-1:0] t_ext [NSLOT+1];
    logic [NSLOT-1:0] v_nxt;
    logic [TAG_W-1:0] t_nxt [NSLOT];

    // Purpose: extend the schedule with an always-empty slot on top.
    always_comb begin
        v_ext = {1'b0, v_q};
        t_ext[NSLOT] = '0;
        for (int i = 0; i < NSLOT; i++) begin
            t_ext[i] = tag_q[i];
        end
    end

    // Purpose: shift every entry down one slot and insert the new one.
    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            v_nxt[i] = v_ext[i+1];
            t_nxt[i] = t_ext[i+1];
            if (ins_valid && (ins_pos == POS_W'(i))) begin
                v_nxt[i] = 1'b1;
                t_nxt[i] = ins_tag;
            end
        end
    end

    // Purpose: slot registers, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            v_q <= v_nxt;
        end
        for (int i = 0; i < NSLOT; i++) begin
            tag_q[i] <= t_nxt[i];
        end
    end

    assign slot_busy = v_q;
    assign wb_en     = v_q[0];
    assign wb_tag    = tag_q[0];

    // R6: an insertion never lands on a slot still holding an entry
    p_slot_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> !v_ext[POS_W'(ins_pos + 1'b1)]);

endmodule

// File: rtl/wbs_perf_cnt.sv
// Event counters for issue, stall and write events.
// Counters wrap at their width. Assumes each event input is one pulse
// per cycle.
module wbs_perf_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_issue,
    input  logic             ev_bubble,
    input  logic             ev_write,
    output logic [CNT_W-1:0] cnt_issued,
    output logic [CNT_W-1:0] cnt_bubbles,
    output logic [CNT_W-1:0] cnt_writes
);

    // Purpose: count the three events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_issued  <= '0;
            cnt_bubbles <= '0;
            cnt_writes  <= '0;
        end else begin
            cnt_issued  <= cnt_issued  + CNT_W'(ev_issue);
            cnt_bubbles <= cnt_bubbles + CNT_W'(ev_bubble);
            cnt_writes  <= cnt_writes  + CNT_W'(ev_write);
        end
    end

    // R8: a stall cycle is never also counted as an issue
    p_stall_not_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bubble |-> !ev_issue);

endmodule

// File: rtl/wbs_writeback_sched.sv
// Top of the writeback port conflict scheduler.
// Accepts one instruction per cycle over valid/ready. Keeps the
// register write port free of double grants by stalling or padding,
// as selected by mode_pad. Assumes the source holds its offer stable
// while in_ready is low.
module wbs_writeback_sched #(
    parameter int TAG_W       = 4,
    parameter int CNT_W       = 16,
    parameter int LOAD_STAGES = 5,
    parameter int ALU_STAGES  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_pad,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             in_is_load,
    output logic             wb_en,
    output logic [TAG_W-1:0] wb_tag,
    output logic [CNT_W-1:0] cnt_issued,
    output logic [CNT_W-1:0] cnt_bubbles,
    output logic [CNT_W-1:0] cnt_writes
);

    localparam int NSLOT = LOAD_STAGES - 1;
    localparam int POS_W = $clog2(NSLOT + 1);

    logic [NSLOT-1:0] slot_busy;
    logic             ins_valid;
    logic [POS_W-1:0] ins_pos;
    logic             bubble;

    wbs_issue_ctrl #(
        .LOAD_STAGES (LOAD_STAGES),
        .ALU_STAGES  (ALU_STAGES)
    ) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_pad   (mode_pad),
        .in_valid   (in_valid),
        .in_is_load (in_is_load),
        .slot_busy  (slot_busy),
        .in_ready   (in_ready),
        .ins_valid  (ins_valid),
        .ins_pos    (ins_pos),
        .bubble     (bubble)
    );

    wbs_slot_track #(
        .TAG_W       (TAG_W),
        .LOAD_STAGES (LOAD_STAGES)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_valid (ins_valid),
        .ins_pos   (ins_pos),
        .ins_tag   (in_tag),
        .slot_busy (slot_busy),
        .wb_en     (wb_en),
        .wb_tag    (wb_tag)
    );

    wbs_perf_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_issue    (ins_valid),
        .ev_bubble   (bubble),
        .ev_write    (wb_en),
        .cnt_issued  (cnt_issued),
        .cnt_bubbles (cnt_bubbles),
        .cnt_writes  (cnt_writes)
    );

    // Latency checks, written for the default stage counts only.
    if (LOAD_STAGES == 5 && ALU_STAGES == 4) begin : g_lat_chk
        // R2: a load writes four cycles after it is accepted
        p_load_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_ready && in_is_load) |->
                ##4 (wb_en && (wb_tag == $past(in_tag, 4))));

        // R3: an unpadded short instruction writes three cycles later
        p_alu_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_ready && !in_is_load && !mode_pad) |->
                ##3 (wb_en && (wb_tag == $past(in_tag, 3))));

        // R5: a padded short instruction writes four cycles later
        p_pad_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_ready && !in_is_load && mode_pad) |->
                ##4 (wb_en && (wb_tag == $past(in_tag, 4))));
    end

endmodule

// File: tb/wbs_writeback_sched_bench.sv
// Directed bench for the writeback scheduler. Write events are logged
// per cycle at the falling edge and compared against cycle numbers
// recorded at each accepted handshake.
module wbs_writeback_sched_bench;

    localparam int TW = 4;
    localparam int CW = 16;
    localparam int LOGN = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_pad = 1'b0;
    logic          in_valid = 1'b0;
    logic [TW-1:0] in_tag = '0;
    logic          in_is_load = 1'b0;
    logic          in_ready;
    logic          wb_en;
    logic [TW-1:0] wb_tag;
    logic [CW-1:0] cnt_issued, cnt_bubbles, cnt_writes;

    wbs_writeback_sched #(.TAG_W(TW), .CNT_W(CW)) u_wbs_writeback_sched (
        .clk(clk), .rst_n(rst_n), .mode_pad(mode_pad),
        .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag),
        .in_is_load(in_is_load), .wb_en(wb_en), .wb_tag(wb_tag),
        .cnt_issued(cnt_issued), .cnt_bubbles(cnt_bubbles),
        .cnt_writes(cnt_writes)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    bit            en_log  [LOGN];
    logic [TW-1:0] tag_log [LOGN];
    always @(negedge clk) begin
        if (cyc < LOGN) begin
            en_log[cyc]  = wb_en;
            tag_log[cyc] = wb_tag;
        end
    end

    int n_checks = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
    endtask

    // Offer one instruction; return its accept cycle and the stall count.
    task automatic offer(input logic [TW-1:0] t, input bit ld,
                         output int acc, output int stalls);
        stalls = 0;
        @(negedge clk);
        in_valid = 1'b1; in_tag = t; in_is_load = ld;
        #1;
        while (!in_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        acc = cyc;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (8) @(negedge clk);
    endtask

    task automatic expect_wb(input int c, input logic [TW-1:0] t, input string req);
        check(en_log[c] == 1'b1, req, "write enable", int'(en_log[c]), 1);
        check(tag_log[c] == t, req, "write tag", int'(tag_log[c]), int'(t));
    endtask

    task automatic expect_quiet(input int c, input string req);
        check(en_log[c] == 1'b0, req, "no write", int'(en_log[c]), 0);
    endtask

    // R1 and R9: reset state, then an idle pipeline stays silent.
    task automatic t_reset_idle();
        @(negedge clk);
        in_valid = 1'b1; in_tag = 4'd3; in_is_load = 1'b1;
        #1;
        check(in_ready == 1'b0, "R1", "ready in reset", int'(in_ready), 0);
        check(wb_en == 1'b0, "R1", "wb_en in reset", int'(wb_en), 0);
        @(negedge clk);
        check(cnt_issued == 0 && cnt_bubbles == 0 && cnt_writes == 0, "R1",
              "counters in reset", int'(cnt_issued + cnt_bubbles + cnt_writes), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        repeat (7) @(negedge clk);
        for (int c = cyc - 6; c <= cyc; c++) expect_quiet(c, "R9");
        check(cnt_issued == 0, "R9", "issued while idle", int'(cnt_issued), 0);
    endtask

    // R2: lone load latency.
    task automatic t_single_load();
        int a, s;
        mode_pad = 1'b0;
        offer(4'd5, 1'b1, a, s);
        drain();
        for (int k = 1; k <= 3; k++) expect_quiet(a + k, "R2");
        expect_wb(a + 4, 4'd5, "R2");
    endtask

    // R3: lone short instruction in stall mode.
    task automatic t_single_alu();
        int a, s;
        mode_pad = 1'b0;
        offer(4'd6, 1'b0, a, s);
        drain();
        expect_wb(a + 3, 4'd6, "R3");
        expect_quiet(a + 4, "R3");
    endtask

    // R4, R6, R8: load followed at once by a short one in stall mode.
    task automatic t_load_then_alu();
        int a1, a2, s1, s2;
        int b0, i0, w0;
        mode_pad = 1'b0;
        b0 = cnt_bubbles; i0 = cnt_issued; w0 = cnt_writes;
        offer(4'd1, 1'b1, a1, s1);
        offer(4'd2, 1'b0, a2, s2);
        drain();
        check(s2 == 1, "R4", "stall cycles", s2, 1);
        check(a2 == a1 + 2, "R4", "accept cycle", a2, a1 + 2);
        expect_wb(a1 + 4, 4'd1, "R6");
        expect_wb(a2 + 3, 4'd2, "R6");
        check(int'(cnt_bubbles) - b0 == 1, "R8", "bubble count",
              int'(cnt_bubbles) - b0, 1);
        check(int'(cnt_issued) - i0 == 2, "R8", "issue count",
              int'(cnt_issued) - i0, 2);
        check(int'(cnt_writes) - w0 == 2, "R8", "write count",
              int'(cnt_writes) - w0, 2);
    endtask

    // R3: short then load in stall mode needs no stall and leaves a gap.
    task automatic t_alu_then_load();
        int a1, a2, s1, s2;
        mode_pad = 1'b0;
        offer(4'd7, 1'b0, a1, s1);
        offer(4'd8, 1'b1, a2, s2);
        drain();
        check(s2 == 0, "R3", "stall cycles", s2, 0);
        expect_wb(a1 + 3, 4'd7, "R3");
        expect_quiet(a1 + 4, "R3");
        expect_wb(a2 + 4, 4'd8, "R2");
    endtask

    // R5: pad mode, load then short, no stall, short writes at +4.
    task automatic t_pad_pair();
        int a1, a2, s1, s2;
        int b0;
        mode_pad = 1'b1;
        b0 = cnt_bubbles;
        offer(4'd9, 1'b1, a1, s1);
        offer(4'd10, 1'b0, a2, s2);
        drain();
        check(s2 == 0, "R5", "stall cycles", s2, 0);
        expect_wb(a1 + 4, 4'd9, "R5");
        expect_wb(a2 + 4, 4'd10, "R5");
        check(int'(cnt_bubbles) == b0, "R5", "bubble count", int'(cnt_bubbles), b0);
    endtask

    // R7, R6: mixed stream in pad mode writes every cycle in order.
    task automatic t_pad_stream();
        int acc [8];
        int s, tot;
        mode_pad = 1'b1;
        tot = 0;
        for (int i = 0; i < 8; i++) begin
            offer(TW'(i), (i % 3) == 0, acc[i], s);
            tot += s;
        end
        drain();
        check(tot == 0, "R7", "stalls in stream", tot, 0);
        for (int i = 0; i < 8; i++) begin
            check(acc[i] == acc[0] + i, "R7", "accept cycle", acc[i], acc[0] + i);
            expect_wb(acc[0] + 4 + i, TW'(i), "R7");
        end
    endtask

    // R7: short-only stream in stall mode, one write per cycle.
    task automatic t_alu_stream();
        int acc [6];
        int s, tot;
        mode_pad = 1'b0;
        tot = 0;
        for (int i = 0; i < 6; i++) begin
            offer(TW'(i + 3), 1'b0, acc[i], s);
            tot += s;
        end
        drain();
        check(tot == 0, "R7", "stalls in stream", tot, 0);
        for (int i = 0; i < 6; i++) expect_wb(acc[0] + 3 + i, TW'(i + 3), "R7");
    endtask

    // R6, R4, R8: load/short alternating in stall mode, order kept.
    task automatic t_mixed_stall();
        int acc [6];
        int s, tot, seen, b0;
        logic [TW-1:0] got [6];
        mode_pad = 1'b0;
        tot = 0;
        b0 = cnt_bubbles;
        for (int i = 0; i < 6; i++) begin
            offer(TW'(i + 10), (i % 2) == 0, acc[i], s);
            tot += s;
        end
        drain();
        check(tot == 3, "R4", "stalls in mixed stream", tot, 3);
        check(int'(cnt_bubbles) - b0 == 3, "R8", "bubble count",
              int'(cnt_bubbles) - b0, 3);
        seen = 0;
        for (int c = acc[0]; c <= acc[5] + 5; c++) begin
            if (en_log[c]) begin
                if (seen < 6) got[seen] = tag_log[c];
                seen++;
            end
        end
        check(seen == 6, "R6", "write count", seen, 6);
        for (int i = 0; i < 6 && i < seen; i++)
            check(got[i] == TW'(i + 10), "R6", "write order", int'(got[i]), i + 10);
    endtask

    initial begin
        t_reset_idle();
        t_single_load();
        t_single_alu();
        t_load_then_alu();
        t_alu_then_load();
        t_pad_pair();
        t_pad_stream();
        t_alu_stream();
        t_mixed_stall();
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule